// File: doc/BRIEF.md
# Stereo Audio Serial Output Formatter

The formatter takes one stereo pair of 16-bit two's-complement samples per sample period and sends it out on a single serial data line, MSB first. It drives its own bit clock, divided down from the system clock, and a left/right word clock. Left and right words take turns on the one data line. Each slot's bit is launched on a falling bit clock edge, so the receiver samples it on the rising edge.

A static 3-bit format select picks the frame layout. Four layouts use a 64-slot frame, in which each sample owns one 32-slot half: right-justified, I2S (one-slot delay), left-justified, or word-clock-controlled placement. In the last of these, a pulse on an input marks the slot where each word's MSB begins. Two packed layouts put both samples into one 32-slot frame, either left-justified or I2S. Every slot that carries no sample bit reads zero. An upstream producer writes each pair into a staging register whenever it likes. The formatter copies that register into its shift copy only at the start of each frame's data, so a word never changes while it is being shifted.

Top module: `stereo_ser_fmt`

## Requirements
- R1: While rst_n is low, bclk_o is high and sdata_o is low. lrck_o is high in formats 1 and 5 and low in every other format.
- R2: The bit clock has a period of 2*BCLK_HALF system clocks with equal high and low times. sdata_o and lrck_o change only in the cycle where bclk_o falls. The first falling edge after reset begins slot 0.
- R3: Formats 4 and 5 use a 32-slot frame. All other codes use a 64-slot frame. The left sample belongs to the first half of the frame.
- R4: In formats 1 and 5, lrck_o is low during the first half of the frame and high during the second. In every other format it is high during the first half and low during the second.
- R5: Left-justified formats (2 wide, 4 packed): a sample's MSB is in the first slot of its half. Its remaining 15 bits follow, most significant first. Any later slots in the half are zero.
- R6: I2S formats (1 wide, 5 packed): placement is as in R5 but one slot later. In format 5, the right sample's LSB therefore falls in slot 0 of the following frame.
- R7: Right-justified format (0): the first 16 slots of each 32-slot half are zero, and the sample's LSB is in the last slot of the half.
- R8: Word-clock-controlled format (3): wck_in is sampled at every falling bit clock edge. When it is high, the slot starting at that edge carries the MSB of the sample that owns that half. Following slots carry the next bits until 16 have been sent or the half ends. A new pulse restarts the word. All other slots are zero.
- R9: smp_load captures smp_left and smp_right into staging. The staged pair is transferred for output on entry to slot 0, or to slot 1 in formats 1 and 5. Loads at other times leave the frame in progress unchanged.
- R10: Codes 6 and 7 are spare: they use a 64-slot frame and keep sdata_o at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 3 | Static frame format code |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| smp_load | input | 1 | Capture the sample pair into staging |
| wck_in | input | 1 | Word start marker for format 3 |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Left/right word clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that fmt_sel is held constant whenever rst_n is high, and that no smp_load coincides with the falling bit clock edge that starts a frame's data. The bench changes the format only while reset is asserted. It pulses smp_load only a few slots after the data start and again at mid-frame, so the first load of each frame also tests that the word being shifted is unaffected. In format 3, wck_in is set for one whole bit clock period at a time, so it is stable across the falling edge that samples it. Directed pulses just before a half boundary exercise the truncated word.

// File: rtl/stereo_ser_fmt.sv
module stereo_ser_fmt #(
  parameter int SAMPLE_W  = 16,
  parameter int FIELD_W   = 32,
  parameter int BCLK_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                smp_load,
  input  logic                wck_in,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdata_o
);
  localparam int WIDE = 2 * FIELD_W;
  localparam int PACK = 2 * SAMPLE_W;
  localparam int SW   = $clog2(WIDE);
  localparam int SW1  = SW + 1;
  localparam int DW   = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam int PW   = $clog2(SAMPLE_W) + 1;

  logic [DW-1:0]       div_q;
  logic                bclk_q;
  logic [SW-1:0]       slot_q;
  logic                sdata_q;
  logic [PW-1:0]       wpos_q;
  logic [SAMPLE_W-1:0] stg_l, stg_r, pair_l, pair_r;

  logic                pk, i2s, last, tick, take, cur_rh, nxt_rh, nbit;
  logic [SW1-1:0]      flen, hlen;
  logic [SW-1:0]       nslot;
  logic [PW-1:0]       nwpos;
  logic [SAMPLE_W-1:0] src_l, src_r, w, sh;
  int                  p_i, q_i, h_i;

  assign pk     = (fmt_sel == 3'd4) || (fmt_sel == 3'd5);
  assign i2s    = (fmt_sel == 3'd1) || (fmt_sel == 3'd5);
  assign flen   = pk ? SW1'(PACK) : SW1'(WIDE);
  assign hlen   = flen >> 1;
  assign last   = {1'b0, slot_q} == flen - 1'b1;
  assign nslot  = last ? '0 : slot_q + 1'b1;
  assign tick   = (div_q == DW'(BCLK_HALF - 1)) && bclk_q;
  assign take   = tick && ({1'b0, nslot} == SW1'(i2s));
  assign src_l  = take ? stg_l : pair_l;
  assign src_r  = take ? stg_r : pair_r;
  assign cur_rh = {1'b0, slot_q} >= hlen;
  assign nxt_rh = {1'b0, nslot} >= hlen;

  always_comb begin
    h_i   = int'(hlen);
    p_i   = int'(nslot) - (i2s ? 1 : 0);
    if (p_i < 0) p_i = p_i + int'(flen);
    q_i   = (p_i >= h_i) ? p_i - h_i : p_i;
    w     = (p_i >= h_i) ? src_r : src_l;
    sh    = '0;
    nbit  = 1'b0;
    nwpos = wpos_q;
    case (fmt_sel)
      3'd0: if (q_i >= h_i - SAMPLE_W) begin
        sh   = w >> (h_i - 1 - q_i);
        nbit = sh[0];
      end
      3'd1, 3'd2, 3'd4, 3'd5: if (q_i < SAMPLE_W) begin
        sh   = w >> (SAMPLE_W - 1 - q_i);
        nbit = sh[0];
      end
      3'd3: begin
        w = nxt_rh ? src_r : src_l;
        if (wck_in) begin
          nbit  = w[SAMPLE_W-1];
          nwpos = PW'(1);
        end else if (wpos_q < PW'(SAMPLE_W) && nxt_rh == cur_rh) begin
          sh    = w >> (SAMPLE_W - 1 - int'(wpos_q));
          nbit  = sh[0];
          nwpos = wpos_q + 1'b1;
        end else begin
          nwpos = PW'(SAMPLE_W);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DW'(BCLK_HALF - 1);
      bclk_q  <= 1'b1;
      slot_q  <= SW'(flen - 1'b1);
      sdata_q <= 1'b0;
      wpos_q  <= PW'(SAMPLE_W);
      stg_l   <= '0;
      stg_r   <= '0;
      pair_l  <= '0;
      pair_r  <= '0;
    end else begin
      if (smp_load) begin
        stg_l <= smp_left;
        stg_r <= smp_right;
      end
      if (div_q == DW'(BCLK_HALF - 1)) begin
        div_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (tick) begin
        slot_q  <= nslot;
        sdata_q <= nbit;
        wpos_q  <= nwpos;
        if (take) begin
          pair_l <= stg_l;
          pair_r <= stg_r;
        end
      end
    end
  end

  assign bclk_o  = bclk_q;
  assign sdata_o = sdata_q;
  assign lrck_o  = i2s ? cur_rh : ~cur_rh;
endmodule

// File: rtl/stereo_ser_fmt_chk.sv
module stereo_ser_fmt_chk #(
  parameter int SAMPLE_W = 16,
  parameter int FIELD_W  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [2:0]                    fmt_sel,
  input logic                          bclk_o,
  input logic                          lrck_o,
  input logic                          sdata_o,
  input logic [$clog2(2*FIELD_W)-1:0]  slot_q,
  input logic [SAMPLE_W-1:0]           pair_l,
  input logic [SAMPLE_W-1:0]           pair_r
);
  logic i2s_f, pk_f;
  assign i2s_f = (fmt_sel == 3'd1) || (fmt_sel == 3'd5);
  assign pk_f  = (fmt_sel == 3'd4) || (fmt_sel == 3'd5);

  // R2
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_o));
  // R2
  lrck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck_o) |-> $fell(bclk_o));
  // R3
  pack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_f |-> int'(slot_q) < 2 * SAMPLE_W);
  // R7
  rj_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel == 3'd0 && (int'(slot_q) % FIELD_W) < FIELD_W - SAMPLE_W) |-> !sdata_o);
  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pair_l) || !$stable(pair_r)) |-> ($fell(bclk_o) && int'(slot_q) == (i2s_f ? 1 : 0)));
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel >= 3'd6) |-> !sdata_o);
endmodule

bind stereo_ser_fmt stereo_ser_fmt_chk #(.SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_o(bclk_o), .lrck_o(lrck_o),
  .sdata_o(sdata_o), .slot_q(slot_q), .pair_l(pair_l), .pair_r(pair_r)
);

// File: tb/test_stereo_ser_fmt.sv
`timescale 1ns/1ps
module test_stereo_ser_fmt;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic        smp_load = 1'b0, wck_in = 1'b0;
  logic        bclk_o, lrck_o, sdata_o;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  stereo_ser_fmt #(.SAMPLE_W(16), .FIELD_W(32), .BCLK_HALF(HALF)) i_stereo_ser_fmt (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .smp_left(smp_left), .smp_right(smp_right),
    .smp_load(smp_load), .wck_in(wck_in), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flen(input logic [2:0] m);
    return (m == 3'd4 || m == 3'd5) ? 32 : 64;
  endfunction

  function automatic bit exp_lr(input logic [2:0] m, input int s);
    int hl = flen(m) / 2;
    if (m == 3'd1 || m == 3'd5) return s >= hl;
    return s < hl;
  endfunction

  function automatic bit exp_bit(input logic [2:0] m, input int s, input logic [15:0] l, input logic [15:0] r);
    int fl = flen(m), hl = flen(m) / 2, d, p, q;
    logic [15:0] w;
    if (m == 3'd3 || m >= 3'd6) return 1'b0;
    d = (m == 3'd1 || m == 3'd5) ? 1 : 0;
    p = (s - d + fl) % fl;
    q = (p >= hl) ? p - hl : p;
    w = (p >= hl) ? r : l;
    if (m == 3'd0) return (q >= hl - 16) ? w[hl-1-q] : 1'b0;
    return (q < 16) ? w[15-q] : 1'b0;
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R7/R9";
      3'd1, 3'd5: return "R6/R9";
      3'd2, 3'd4: return "R5/R9";
      3'd3: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_mode(input logic [2:0] m, input int frames);
    int fl, hl, d, k, s, since, wpos, f;
    bit wh, eb, prevb, psd, plr;
    logic [15:0] ml, mr, pl, pr, w;
    fl = flen(m); hl = fl / 2; d = (m == 3'd1 || m == 3'd5) ? 1 : 0;
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = m; smp_load = 1'b0; wck_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bclk_o === 1'b1 && sdata_o === 1'b0 && lrck_o === exp_lr(m, fl - 1), "R1",
        {bclk_o, lrck_o, sdata_o}, {1'b1, exp_lr(m, fl - 1), 1'b0});
    rst_n = 1'b1;
    ml = '0; mr = '0; pl = '0; pr = '0; k = 0; since = 0; wpos = 16; wh = 1'b0;
    prevb = bclk_o; psd = sdata_o; plr = lrck_o;
    while (k < frames * fl) begin
      @(negedge clk);
      smp_load = 1'b0;
      since++;
      if ((sdata_o !== psd || lrck_o !== plr) && !(prevb && !bclk_o))
        chk(1'b0, "R2 change off falling edge", {sdata_o, lrck_o}, {psd, plr});
      if (bclk_o && !prevb) begin
        s = k % fl;
        f = k / fl;
        if (k > 0) chk(since == 2 * HALF, "R2 period", since, 2 * HALF);
        since = 0;
        if (s == d) begin ml = pl; mr = pr; end
        if (m == 3'd3) begin
          w = (s >= hl) ? mr : ml;
          if (wck_in) begin eb = w[15]; wpos = 1; wh = (s >= hl); end
          else if (wpos < 16 && (s >= hl) == wh) begin eb = w[15-wpos]; wpos++; end
          else begin eb = 1'b0; wpos = 16; end
        end else begin
          eb = exp_bit(m, s, ml, mr);
        end
        chk(sdata_o === eb, {req_of(m), " data"}, sdata_o, eb);
        chk(lrck_o === exp_lr(m, s), "R4 word clock, R3 frame", lrck_o, exp_lr(m, s));
        if (s == d + 2 || s == hl + 2) begin
          if (s == hl + 2 && f < 4) begin
            case (f)
              0: begin pl = 16'h8000; pr = 16'h7FFF; end
              1: begin pl = 16'hFFFF; pr = 16'h0001; end
              2: begin pl = 16'h0000; pr = 16'hFFFF; end
              default: begin pl = 16'hA5A5; pr = 16'h5A5A; end
            endcase
          end else begin
            pl = 16'($urandom); pr = 16'($urandom);
          end
          smp_left = pl; smp_right = pr; smp_load = 1'b1;
        end
        if (m == 3'd3)
          wck_in = ((s + 1) % fl == 3) || ((s + 1) % fl == hl - 5) || ($urandom_range(0, 11) == 0);
        k++;
      end
      prevb = bclk_o; psd = sdata_o; plr = lrck_o;
    end
    wck_in = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int m = 0; m < 8; m++)
      run_mode(3'(m), (m == 3) ? 30 : 10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule